// File: doc/BRIEF.md
# Parallel Channel Acquire Command Latch

This block is the parallel control port of a multi-channel sample-and-hold array. When a board strap selects parallel control, it watches an active-low chip select and an active-low write strobe. On each rising edge of the strobe it captures a 5-bit channel address, an offset-select line and a calibrate line. From these it issues a single-cycle acquire command: one channel, the dedicated offset channel, or every main channel at once. The same strap tells the serial receiver whether it may run. The serial receiver is enabled only while the parallel port is not selected.

The command is a one-hot acquire-enable vector. Bits 0 to 31 are the main channels and bit 32 is the offset channel. Each accepted command starts a busy window whose length in system clock cycles comes from an input. A strobe edge that arrives inside the window is dropped and sets a sticky overflow flag. All inputs are synchronous to `clk`. A strobe rising edge is detected when `wr_n` reads low at one clock edge and high at the next.

Top module: `par_acq_latch`

## Requirements
- R1: After reset, `acq_en` is all zero, and `busy` and `overflow` are low.
- R2: A write is accepted when `wr_n` rises while `cs_n` is low, `ser_par_n` is low and the block is not busy. The clock edge that first samples `wr_n` high loads `acq_en`, and `acq_en` is non-zero for exactly that one cycle.
- R3: With `cal` and `ofs_sel` low, `acq_en` has only bit `addr` set. `addr[4]` is the MSB, so `addr` = 0 gives bit 0 and `addr` = 31 gives bit 31.
- R4: With `ofs_sel` high and `cal` low, `acq_en` is exactly bit 32, whatever value `addr` has.
- R5: With `cal` high, bits 31..0 of `acq_en` are all set and bit 32 is clear, whatever `ofs_sel` and `addr` are.
- R6: A `wr_n` rising edge that occurs while `cs_n` is high produces no command, no busy window and no overflow.
- R7: While `ser_par_n` is high, strobe edges produce no command, and `serial_en` is high. While `ser_par_n` is low, `serial_en` is low.
- R8: `busy` rises in the cycle the command appears and stays high for exactly `busy_len` cycles.
- R9: A strobe edge that would be accepted but arrives while `busy` is high produces no command and sets `overflow`. `overflow` stays set until reset.
- R10: With `busy_len` = 0, `busy` never rises, and writes on consecutive strobe edges are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_par_n | input | 1 | Strap: low selects the parallel port |
| cs_n | input | 1 | Active-low chip select, shared with the serial frame select |
| wr_n | input | 1 | Active-low write strobe; fields are captured on its rising edge |
| addr | input | 5 | Channel address, bit 4 is the MSB |
| ofs_sel | input | 1 | Selects the offset channel in place of `addr` |
| cal | input | 1 | Broadcasts the acquire to all 32 main channels |
| busy_len | input | 8 | Length of the busy window in cycles |
| acq_en | output | 33 | One-cycle acquire enables; bit 32 is the offset channel |
| busy | output | 1 | High while a command's window runs |
| overflow | output | 1 | Sticky: a write was dropped because the block was busy |
| serial_en | output | 1 | Enables the serial receiver |

## Verification
The bench drives both end addresses to catch any reversal of bit order. It also sets `ofs_sel` and `cal` together with a non-zero address. A wrong priority would leak the address bit, or the offset bit, into the broadcast. The bench counts the length of each pulse and each busy window exactly, so a command that lingers or a window that is off by one shows up as a wrong count. It also raises strobes while chip select is high, while the strap is high and inside the busy window, and then confirms at the ports that none of them left a trace. A design that ignored any of those gates would emit a command, start a window, or fail to set `overflow`.

// File: rtl/par_acq_latch.sv
module par_acq_latch #(
  parameter int NCH = 32,
  parameter int BW  = 8,
  localparam int AW = $clog2(NCH),
  localparam int EW = NCH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_par_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic          ofs_sel,
  input  logic          cal,
  input  logic [BW-1:0] busy_len,
  output logic [EW-1:0] acq_en,
  output logic          busy,
  output logic          overflow,
  output logic          serial_en
);

  logic          wr_q;
  logic [BW-1:0] busy_cnt;
  logic          strobe_rise;
  logic          hit;
  logic          accept;
  logic [EW-1:0] cmd;

  assign serial_en   = ser_par_n;
  assign strobe_rise = ~wr_q & wr_n;
  assign hit         = strobe_rise & ~cs_n & ~ser_par_n;
  assign accept      = hit & (busy_cnt == '0);
  assign busy        = busy_cnt != '0;

  always_comb begin
    cmd = '0;
    if (cal)          cmd[NCH-1:0] = '1;
    else if (ofs_sel) cmd[NCH] = 1'b1;
    else              cmd[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      acq_en   <= '0;
      busy_cnt <= '0;
      overflow <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      acq_en <= accept ? cmd : '0;
      if (accept)    busy_cnt <= busy_len;
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (hit && busy) overflow <= 1'b1;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en != '0) |=> (acq_en == '0));
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en[NCH-1:0] != '1) |-> $onehot0(acq_en));
  a_r5_cal_excludes_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en[NCH-1:0] == '1) |-> !acq_en[NCH]);
  a_r7_strap_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en != '0) |-> $past(!ser_par_n && !cs_n));
  a_r9_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));
  a_r9_no_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en != '0) |-> $past(!busy));

endmodule

// File: tb/test_par_acq_latch.sv
module test_par_acq_latch;
  logic        clk = 0, rst_n = 0;
  logic        ser_par_n = 0, cs_n = 1, wr_n = 1, ofs_sel = 0, cal = 0;
  logic [4:0]  addr = 0;
  logic [7:0]  busy_len = 0;
  logic [32:0] acq_en;
  logic        busy, overflow, serial_en;
  int nchk = 0, nfail = 0;

  logic [32:0] last_cmd;
  int pulses, busy_cyc;

  always #5 clk = ~clk;

  par_acq_latch i_par_acq_latch (.clk, .rst_n, .ser_par_n, .cs_n, .wr_n, .addr,
    .ofs_sel, .cal, .busy_len, .acq_en, .busy, .overflow, .serial_en);

  always @(negedge clk) begin
    if (acq_en != 0) begin last_cmd = acq_en; pulses++; end
    if (busy) busy_cyc++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    last_cmd = 0; pulses = 0; busy_cyc = 0;
  endtask

  task automatic strobe(logic c, logic [4:0] a, logic o, logic k);
    @(negedge clk); cs_n = c; addr = a; ofs_sel = o; cal = k; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 acq_en", acq_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_channel(logic [4:0] a);
    busy_len = 0; clr();
    strobe(0, a, 0, 0); wait_n(3);
    chk("R3 channel bit", last_cmd, 33'd1 << a);
    chk("R2 one pulse", pulses, 1);
  endtask

  task automatic t_timing();
    busy_len = 0; clr();
    @(negedge clk); cs_n = 0; addr = 5'd4; wr_n = 0;
    @(negedge clk); wr_n = 1;
    chk("R2 not before edge", acq_en, 0);
    @(negedge clk);
    chk("R2 pulse cycle", acq_en, 33'd1 << 4);
    @(negedge clk);
    chk("R2 pulse ends", acq_en, 0);
    cs_n = 1;
  endtask

  task automatic t_offset();
    clr(); strobe(0, 5'd9, 1, 0); wait_n(3);
    chk("R4 offset only", last_cmd, 33'h1_0000_0000);
  endtask

  task automatic t_cal();
    clr(); strobe(0, 5'd3, 0, 1); wait_n(3);
    chk("R5 broadcast", last_cmd, 33'h0_FFFF_FFFF);
    clr(); strobe(0, 5'd31, 1, 1); wait_n(3);
    chk("R5 cal over offset", last_cmd, 33'h0_FFFF_FFFF);
    chk("R5 one pulse", pulses, 1);
  endtask

  task automatic t_cs_high();
    busy_len = 4; clr(); strobe(1, 5'd2, 0, 0); wait_n(6);
    chk("R6 no command", pulses, 0);
    chk("R6 no busy", busy_cyc, 0);
    chk("R6 no overflow", overflow, 0);
  endtask

  task automatic t_strap();
    busy_len = 0;
    chk("R7 serial_en low", serial_en, 0);
    ser_par_n = 1; clr(); strobe(0, 5'd6, 0, 0); wait_n(3);
    chk("R7 serial_en high", serial_en, 1);
    chk("R7 no command", pulses, 0);
    ser_par_n = 0;
  endtask

  task automatic t_busy();
    busy_len = 5; clr(); strobe(0, 5'd1, 0, 0); wait_n(8);
    chk("R8 busy length", busy_cyc, 5);
    busy_len = 1; clr(); strobe(0, 5'd2, 0, 0); wait_n(4);
    chk("R8 busy length one", busy_cyc, 1);
  endtask

  task automatic t_overflow();
    busy_len = 20; clr();
    strobe(0, 5'd7, 0, 0);
    chk("R9 overflow clear before", overflow, 0);
    strobe(0, 5'd8, 0, 0); wait_n(25);
    chk("R9 rejected", pulses, 1);
    chk("R9 first kept", last_cmd, 33'd1 << 7);
    chk("R9 overflow set", overflow, 1);
    busy_len = 0; clr(); strobe(0, 5'd10, 0, 0); wait_n(3);
    chk("R9 sticky", overflow, 1);
    chk("R9 accepts after window", last_cmd, 33'd1 << 10);
  endtask

  task automatic t_zero_len();
    busy_len = 0; clr();
    @(negedge clk); cs_n = 0; addr = 5'd12; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); wr_n = 0; addr = 5'd13;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    wait_n(3);
    chk("R10 back to back", pulses, 2);
    chk("R10 second cmd", last_cmd, 33'd1 << 13);
    chk("R10 never busy", busy_cyc, 0);
  endtask

  initial begin
    fork
      begin
        wait_n(2); rst_n = 1;
        t_reset();
        t_timing();
        t_channel(5'd0);
        t_channel(5'd31);
        t_channel(5'd17);
        t_offset();
        t_cal();
        t_cs_high();
        t_strap();
        t_busy();
        t_zero_len();
        t_overflow();
      end
      begin
        wait_n(20000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule